// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block holds the per-channel control words of a five-channel DMA controller and decides, cycle by cycle, whether each channel may run. Software reaches it over a simple 32-bit register bus with a combinational read path. Each channel has a control word and a read-only status word. The control word holds an enable bit, a pause bit, a software trigger, the request-source selects, a block size and a 16-bit transfer count. Two global inputs come from the all-channel control register: a master enable and a 4-bit hold field. A per-channel step strobe comes from the transfer engine, which is outside this block.

A channel runs when its enable bit is set, the master enable is high, the hold field is zero and its own pause bit is clear. While it runs, each step strobe decrements the count. The step that takes the count from 1 to 0 clears the enable bit. A setting written while the channel is not running goes into a shadow copy and stays pending. The shadow is copied into the active word on the first clock edge at which the channel runs. Each channel's status word reports why the channel stopped, or that it is paused. Transfer requests are granted only to running channels. A request that arrives for any other channel is dropped and is not remembered.

Top module: `dmacsr_top`

## Requirements
- R1: After reset every enable bit and pause bit is 0. `chanEnable`, `chanPaused` and `reqGrant` are 0, and every status code reads 010.
- R2: Channel n's control word is at byte address 0x200+8n and its status word at 0x204+8n, for n from 0 to 4. In the control word, bit 31 is enable, bit 30 is pause, bit 29 is the software trigger, bits 28:24 select the request source, bits 23:20 select the external source, bits 19:16 hold the block size and bits 15:0 hold the transfer count. The status word carries the stop code in bits 18:16 and reads 0 elsewhere. Any other address reads 0, and writes to it change nothing.
- R3: A write of 1 to bit 31 while `globalEnable` is 0 is ignored, and the channel stays disabled.
- R4: If `globalEnable` is 0 at a clock edge, every enabled channel is disabled at that edge and its stop code becomes 011.
- R5: Writing 0 to bit 31 of an enabled channel disables it at the next edge, and its stop code becomes 010.
- R6: While a channel runs, each `xferStep` pulse decrements bits 15:0 by one. The pulse that takes the count from 1 to 0 clears the enable bit and sets stop code 001. A count of 0 wraps to 0xFFFF and the channel keeps running.
- R7: Bits 29:0 written while the channel runs take effect at that write's clock edge.
- R8: Bits 29:0 written while the channel is not started are held pending and read back unchanged. They are applied at the first edge at which the channel runs, which is two edges after the write that enables the channel.
- R9: An enabled channel is paused while `globalHold` is nonzero or its pause bit is 1. While paused, `chanPaused` is 1, the stop code reads 100, step pulses are ignored and written settings stay pending. Pending settings are applied at the first edge after the pause ends.
- R10: `reqGrant[n]` is high only while channel n runs and either `xferReq[n]` or its trigger bit 29 is 1. A granted trigger bit clears at that edge. A request made while the channel is not running produces no grant, either then or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 12 | Byte address for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from busAddr |
| globalEnable | input | 1 | Master enable for all channels |
| globalHold | input | 4 | Global hold field; any nonzero value pauses every channel |
| xferReq | input | 5 | Per-channel transfer request |
| xferStep | input | 5 | Per-channel one-transfer-done strobe from the engine |
| chanEnable | output | 5 | Per-channel enable bit |
| chanPaused | output | 5 | Enabled and temporarily stopped |
| reqGrant | output | 5 | Accepted request, per channel |

## Verification
The grant, paused and read-data outputs are combinational. They are checked one time unit after the falling edge at which their inputs change. Enable bits, stop codes and settings written directly change at the first rising edge after a write or step. Pending settings appear one edge later than the enable write, or one edge after the hold or pause is lifted. The bench therefore reads just before and just after that edge to pin down the exact cycle. All stimulus is driven on falling edges, so each write or step covers exactly one rising edge.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int DATA_W    = 32;
  localparam int BIT_EN    = 31;
  localparam int BIT_PAUSE = 30;
  localparam int BIT_TRIG  = 29;
  localparam int SET_W     = 30;   // bits 29:0 are the shadowed settings
  localparam int STAT_LSB  = 16;   // stop code position in the status word

  typedef enum logic [2:0] {
    STOP_RUN    = 3'b000,
    STOP_DONE   = 3'b001,
    STOP_FORCED = 3'b010,
    STOP_GLOBAL = 3'b011,
    STOP_PAUSED = 3'b100
  } stopCode_t;

  // control -> datapath strobes, one bundle per channel
  typedef struct packed {
    logic wrDirect;
    logic wrShadow;
    logic applyShadow;
    logic countStep;
    logic clearTrig;
  } chanStrobe_t;
endpackage

// File: rtl/dmacsr_ctrl.sv
module dmacsr_ctrl
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int STRIDE    = 8,
  parameter int HOLD_W    = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     wrEnBit,
  input  logic                     wrPauseBit,
  input  logic                     globalEnable,
  input  logic [HOLD_W-1:0]        globalHold,
  input  logic [NUM_CH-1:0]        xferReq,
  input  logic [NUM_CH-1:0]        xferStep,
  input  logic [NUM_CH-1:0]        trigActive,
  input  logic [NUM_CH-1:0]        cntIsOne,
  output chanStrobe_t [NUM_CH-1:0] strobe,
  output logic [NUM_CH-1:0]        chanEnable,
  output logic [NUM_CH-1:0]        chanPaused,
  output logic [NUM_CH-1:0]        pauseBit,
  output logic [NUM_CH-1:0]        reqGrant,
  output logic [NUM_CH-1:0]        wordHit,
  output logic [NUM_CH-1:0]        statHit,
  output stopCode_t [NUM_CH-1:0]   stopCode
);
  localparam int STATUS_OFS = STRIDE / 2;

  logic holdAny;
  assign holdAny = |globalHold;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic      enReg;
    logic      pauseReg;
    stopCode_t reasonReg;
    logic      running;
    logic      wr;

    assign wordHit[ch] = (busAddr == ADDR_W'(BASE_ADDR + ch * STRIDE));
    assign statHit[ch] = (busAddr == ADDR_W'(BASE_ADDR + ch * STRIDE + STATUS_OFS));
    assign wr          = busWrEn & wordHit[ch];
    assign running     = enReg & globalEnable & ~holdAny & ~pauseReg;

    assign strobe[ch].wrDirect    = wr & running;
    assign strobe[ch].wrShadow    = wr & ~running;
    assign strobe[ch].applyShadow = running & ~wr;
    assign strobe[ch].countStep   = running & ~wr & xferStep[ch];
    assign strobe[ch].clearTrig   = running & ~wr & trigActive[ch];

    assign reqGrant[ch]   = running & (xferReq[ch] | trigActive[ch]);
    assign chanEnable[ch] = enReg;
    assign pauseBit[ch]   = pauseReg;
    assign chanPaused[ch] = enReg & (holdAny | pauseReg);
    assign stopCode[ch]   = enReg ? ((holdAny | pauseReg) ? STOP_PAUSED : STOP_RUN)
                                  : reasonReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg     <= 1'b0;
        pauseReg  <= 1'b0;
        reasonReg <= STOP_FORCED;
      end else begin
        if (wr) pauseReg <= wrPauseBit;
        if (!globalEnable) begin
          if (enReg) reasonReg <= STOP_GLOBAL;
          enReg <= 1'b0;
        end else if (wr && !wrEnBit) begin
          if (enReg) reasonReg <= STOP_FORCED;
          enReg <= 1'b0;
        end else if (wr && wrEnBit) begin
          enReg <= 1'b1;
        end else if (strobe[ch].countStep && cntIsOne[ch]) begin
          enReg     <= 1'b0;
          reasonReg <= STOP_DONE;
        end
      end
    end
  end
endmodule

// File: rtl/dmacsr_data.sv
module dmacsr_data
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SET_W-1:0]         wrSettings,
  input  chanStrobe_t [NUM_CH-1:0] strobe,
  input  logic [NUM_CH-1:0]        chanEnable,
  input  logic [NUM_CH-1:0]        pauseBit,
  input  logic [NUM_CH-1:0]        wordHit,
  input  logic [NUM_CH-1:0]        statHit,
  input  stopCode_t [NUM_CH-1:0]   stopCode,
  output logic [NUM_CH-1:0]        trigActive,
  output logic [NUM_CH-1:0]        cntIsOne,
  output logic [DATA_W-1:0]        rdData
);
  logic [SET_W-1:0] actReg    [NUM_CH];
  logic [SET_W-1:0] shadowReg [NUM_CH];
  logic             pendReg   [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign trigActive[ch] = actReg[ch][BIT_TRIG];
    assign cntIsOne[ch]   = (actReg[ch][CNT_W-1:0] == CNT_W'(1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actReg[ch]    <= '0;
        shadowReg[ch] <= '0;
        pendReg[ch]   <= 1'b0;
      end else if (strobe[ch].wrDirect) begin
        actReg[ch]  <= wrSettings;
        pendReg[ch] <= 1'b0;
      end else if (strobe[ch].wrShadow) begin
        shadowReg[ch] <= wrSettings;
        pendReg[ch]   <= 1'b1;
      end else if (strobe[ch].applyShadow && pendReg[ch]) begin
        actReg[ch]  <= shadowReg[ch];
        pendReg[ch] <= 1'b0;
      end else begin
        if (strobe[ch].countStep)
          actReg[ch][CNT_W-1:0] <= actReg[ch][CNT_W-1:0] - CNT_W'(1);
        if (strobe[ch].clearTrig)
          actReg[ch][BIT_TRIG] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wordHit[ch]) rdData = rdData | {chanEnable[ch], pauseBit[ch], actReg[ch]};
      if (statHit[ch]) rdData = rdData | (DATA_W'(stopCode[ch]) << STAT_LSB);
    end
  end
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int STRIDE    = 8,
  parameter int HOLD_W    = 4,
  parameter int CNT_W     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              globalEnable,
  input  logic [HOLD_W-1:0] globalHold,
  input  logic [NUM_CH-1:0] xferReq,
  input  logic [NUM_CH-1:0] xferStep,
  output logic [NUM_CH-1:0] chanEnable,
  output logic [NUM_CH-1:0] chanPaused,
  output logic [NUM_CH-1:0] reqGrant
);
  chanStrobe_t [NUM_CH-1:0] strobe;
  stopCode_t   [NUM_CH-1:0] stopCode;
  logic [NUM_CH-1:0] pauseBit, wordHit, statHit, trigActive, cntIsOne;

  dmacsr_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .STRIDE(STRIDE), .HOLD_W(HOLD_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .wrEnBit(busWrData[BIT_EN]), .wrPauseBit(busWrData[BIT_PAUSE]),
    .globalEnable(globalEnable), .globalHold(globalHold),
    .xferReq(xferReq), .xferStep(xferStep),
    .trigActive(trigActive), .cntIsOne(cntIsOne),
    .strobe(strobe), .chanEnable(chanEnable), .chanPaused(chanPaused),
    .pauseBit(pauseBit), .reqGrant(reqGrant),
    .wordHit(wordHit), .statHit(statHit), .stopCode(stopCode)
  );

  dmacsr_data #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) data_i (
    .clk(clk), .rstN(rstN), .wrSettings(busWrData[SET_W-1:0]),
    .strobe(strobe), .chanEnable(chanEnable), .pauseBit(pauseBit),
    .wordHit(wordHit), .statHit(statHit), .stopCode(stopCode),
    .trigActive(trigActive), .cntIsOne(cntIsOne), .rdData(busRdData)
  );
endmodule

// File: rtl/dmacsr_checker.sv
module dmacsr_checker #(
  parameter int NUM_CH    = 5,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h200,
  parameter int STRIDE    = 8,
  parameter int HOLD_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEnBit,
  input logic              globalEnable,
  input logic [HOLD_W-1:0] globalHold,
  input logic [NUM_CH-1:0] chanEnable,
  input logic [NUM_CH-1:0] chanPaused,
  input logic [NUM_CH-1:0] reqGrant
);
  assert_grant_only_running_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant & ~(chanEnable & ~chanPaused)) == '0);

  assert_global_off_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    !globalEnable |=> (chanEnable == '0));

  assert_paused_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chanPaused & ~chanEnable) == '0);

  assert_hold_pauses_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    (globalHold != '0) |-> (chanPaused == chanEnable));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_forced_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == ADDR_W'(BASE_ADDR + ch * STRIDE) && !wrEnBit)
      |=> !chanEnable[ch]);

    assert_set_needs_global_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!chanEnable[ch] && !globalEnable) |=> !chanEnable[ch]);
  end
endmodule

bind dmacsr_top dmacsr_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
  .STRIDE(STRIDE), .HOLD_W(HOLD_W)
) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .wrEnBit(busWrData[31]), .globalEnable(globalEnable), .globalHold(globalHold),
  .chanEnable(chanEnable), .chanPaused(chanPaused), .reqGrant(reqGrant)
);

// File: tb/dmacsr_top_tb_top.sv
module dmacsr_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 19;

  typedef struct packed {
    logic        isWr;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read value
    logic [31:0] mask;
  } vec_t;

  // gEn=1, hold=0 throughout; each entry takes one cycle
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 12'h200, 32'h0502_0003, 32'h0},          // R8 ch0 disabled -> pending
    '{1'b0, 12'h200, 32'h0000_0000, 32'hFFFF_0000},  // R8 unchanged
    '{1'b0, 12'h204, 32'h0002_0000, 32'h0007_0000},  // R1 code 010
    '{1'b1, 12'h200, 32'h8502_0003, 32'h0},          // enable ch0
    '{1'b0, 12'h200, 32'h8000_0000, 32'hFFFF_0000},  // R8 not applied yet
    '{1'b0, 12'h200, 32'h8502_0003, 32'hFFFF_FFFF},  // R8 applied
    '{1'b0, 12'h204, 32'h0000_0000, 32'h0007_0000},  // running code
    '{1'b1, 12'h200, 32'h8000_0007, 32'h0},          // R7 direct
    '{1'b0, 12'h200, 32'h8000_0007, 32'hFFFF_FFFF},  // R7
    '{1'b1, 12'h208, 32'h0000_0009, 32'h0},          // ch1 pending
    '{1'b1, 12'h228, 32'hFFFF_FFFF, 32'h0},          // R2 unmapped
    '{1'b0, 12'h228, 32'h0000_0000, 32'hFFFF_FFFF},  // R2
    '{1'b0, 12'h20C, 32'h0002_0000, 32'h0007_0000},  // R2 ch1 status
    '{1'b1, 12'h220, 32'h8000_0004, 32'h0},          // ch4 enable
    '{1'b0, 12'h220, 32'h8000_0000, 32'h8000_0000},  // R2 ch4 word
    '{1'b0, 12'h220, 32'h8000_0004, 32'hFFFF_FFFF},  // R8
    '{1'b1, 12'h220, 32'h0000_0000, 32'h0},          // R5 forced stop
    '{1'b0, 12'h224, 32'h0002_0000, 32'h0007_0000},  // R5 code 010
    '{1'b0, 12'h220, 32'h0000_0000, 32'h8000_0000}   // R5 disabled
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        busWrEn;
  logic [11:0] busAddr;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        globalEnable;
  logic [3:0]  globalHold;
  logic [4:0]  xferReq, xferStep;
  logic [4:0]  chanEnable, chanPaused, reqGrant;
  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dmacsr_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .globalEnable(globalEnable), .globalHold(globalHold),
    .xferReq(xferReq), .xferStep(xferStep),
    .chanEnable(chanEnable), .chanPaused(chanPaused), .reqGrant(reqGrant)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic busWrite(input logic [11:0] addr, input logic [31:0] data);
    busWrEn = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input string req, input logic [11:0] addr,
                         input logic [31:0] mask, input logic [31:0] exp);
    busAddr = addr;
    #1;
    check(req, busRdData & mask, exp & mask);
    @(negedge clk);
  endtask

  task automatic stepPulse(input logic [4:0] m);
    xferStep = m;
    @(negedge clk);
    xferStep = '0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    globalEnable = 1'b1; globalHold = '0; xferReq = '0; xferStep = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1 enable", {27'd0, chanEnable}, 32'd0);
    check("R1 paused", {27'd0, chanPaused}, 32'd0);
    xferReq = 5'b11111;
    #1;
    check("R1 grant", {27'd0, reqGrant}, 32'd0);
    xferReq = '0;
    busRead("R1 ch3 status", 12'h21C, 32'hFFFF_FFFF, 32'h0002_0000);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) busWrite(VEC[i].addr, VEC[i].data);
      else busRead($sformatf("R2/R7/R8/R5 table entry %0d", i),
                   VEC[i].addr, VEC[i].mask, VEC[i].data);
    end

    // R6: completion on count 1 -> 0
    busWrite(12'h200, 32'h8000_0002);
    stepPulse(5'b00001);
    busRead("R6 count after one step", 12'h200, 32'hFFFF_FFFF, 32'h8000_0001);
    stepPulse(5'b00001);
    check("R6 enable cleared", {31'd0, chanEnable[0]}, 32'd0);
    busRead("R6 word after done", 12'h200, 32'hFFFF_FFFF, 32'h0000_0000);
    busRead("R6 done code", 12'h204, 32'h0007_0000, 32'h0001_0000);

    // R6: count 0 wraps
    busWrite(12'h210, 32'h8000_0000);
    @(negedge clk);
    stepPulse(5'b00100);
    busRead("R6 wrap", 12'h210, 32'hFFFF_FFFF, 32'h8000_FFFF);
    busWrite(12'h210, 32'h4000_0000);

    // R3: enable ignored while master enable low
    globalEnable = 1'b0;
    busWrite(12'h218, 32'h8000_0001);
    #1;
    check("R3 enable ignored", {31'd0, chanEnable[3]}, 32'd0);
    busRead("R3 code", 12'h21C, 32'h0007_0000, 32'h0002_0000);
    globalEnable = 1'b1;

    // R4: master enable drop clears a running channel
    busWrite(12'h208, 32'h8000_0009);
    @(negedge clk);
    #1;
    check("R4 precondition", {31'd0, chanEnable[1]}, 32'd1);
    globalEnable = 1'b0;
    @(negedge clk);
    #1;
    check("R4 enable cleared", {31'd0, chanEnable[1]}, 32'd0);
    busRead("R4 code 011", 12'h20C, 32'h0007_0000, 32'h0003_0000);
    globalEnable = 1'b1;

    // R9: global hold
    busWrite(12'h208, 32'h8000_0009);
    @(negedge clk);
    globalHold = 4'h2;
    #1;
    check("R9 paused by hold", {31'd0, chanPaused[1]}, 32'd1);
    busRead("R9 code 100", 12'h20C, 32'h0007_0000, 32'h0004_0000);
    busWrite(12'h208, 32'h8000_0005);
    stepPulse(5'b00010);
    busRead("R9 held and step ignored", 12'h208, 32'hFFFF_FFFF, 32'h8000_0009);
    globalHold = 4'h0;
    busRead("R9 same cycle as release", 12'h208, 32'hFFFF_FFFF, 32'h8000_0009);
    busRead("R9 applied after release", 12'h208, 32'hFFFF_FFFF, 32'h8000_0005);

    // R9 / R10: pause bit and dropped request
    busWrite(12'h208, 32'hC000_0005);
    #1;
    check("R9 paused by own bit", {31'd0, chanPaused[1]}, 32'd1);
    xferReq = 5'b00010;
    #1;
    check("R10 no grant while paused", {27'd0, reqGrant}, 32'd0);
    @(negedge clk);
    xferReq = '0;
    busWrite(12'h208, 32'h8000_0005);
    #1;
    check("R10 dropped request not kept", {27'd0, reqGrant}, 32'd0);
    check("R9 unpaused", {31'd0, chanPaused[1]}, 32'd0);

    // R10: grants and trigger
    xferReq = 5'b01010;
    #1;
    check("R10 grant running only", {27'd0, reqGrant}, 32'h0000_0002);
    @(negedge clk);
    xferReq = '0;
    busWrite(12'h208, 32'hA000_0005);
    #1;
    check("R10 trigger grant", {27'd0, reqGrant}, 32'h0000_0002);
    @(negedge clk);
    #1;
    check("R10 trigger cleared", {27'd0, reqGrant}, 32'd0);
    busRead("R10 trigger bit readback", 12'h208, 32'hFFFF_FFFF, 32'h8000_0005);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule